// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines and presents a single maskable interrupt request to a processor. Each line is captured on its rising edge into a pending register. Software can block any line through a mask register. The controller raises its interrupt output only when an unmasked pending line outranks every level whose handler is still running. Line 0 has the highest priority and line 7 the lowest.

When the processor acknowledges, the controller drives an 8-bit type number that names the chosen line. The number is a programmable base whose low three bits are replaced by the line number. On the same clock edge the chosen line moves from pending to in-service. An in-service level blocks itself and every lower level, but a higher level can still nest on top of it. Writing the command byte 20h ends the highest-priority service in progress.

Top module: `prioIntCtrl`

## Requirements
- R1: After reset the in-service, pending, mask and base registers all read 00h and `intOut` is low.
- R2: A rising edge on `irqIn[n]` sets pending bit n on the next clock edge. A line that stays high after its acknowledge does not set its pending bit again.
- R3: `intOut` is high exactly when some pending, unmasked level has a lower number than every level currently in service.
- R4: Mask bit n = 1 keeps level n from raising `intOut` and from being chosen at acknowledge. Its pending bit is kept, so clearing the mask bit makes the request active again.
- R5: While `intAck` is high and `intOut` is high, `intVec` equals the base register with bits [2:0] replaced by the lowest-numbered eligible level. At the clock edge that level's in-service bit is set and its pending bit is cleared.
- R6: A request at a level equal to or lower in priority than one in service is held off. A request at a higher-priority level raises `intOut` and nests, so two in-service bits are then set.
- R7: A write of 20h to address 0 clears the lowest-numbered set in-service bit. Any other byte written to address 0 leaves the in-service register unchanged.
- R8: An acknowledge while `intOut` is low changes no state and returns the base with bits [2:0] = 7.
- R9: Register addresses: 0 reads the in-service register and takes commands on write; 1 is the mask (read/write); 2 is the base (read/write, all 8 bits kept); 3 reads the pending register. Bit n of each register belongs to level n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 8 | Request lines, rising-edge captured |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` |
| intOut | output | 1 | Interrupt request to the processor |
| intAck | input | 1 | Interrupt acknowledge from the processor |
| intVec | output | 8 | Type number, valid while `intAck` is high |

## Verification
The bench builds the block with its default parameters: eight levels, an 8-bit bus and end-of-interrupt code 20h. This puts the full range of level numbers in the vector's low three bits, including the lowest-priority line 7 and the spurious value 7. It also lets tests nest two services at once and mask a line while a lower one is granted. The base is programmed to values whose low bits are nonzero, which shows that those bits are replaced rather than added.

// File: rtl/prioIntPkg.sv
package prioIntPkg;
  typedef struct packed {
    logic grant;
    logic eoi;
    logic wrMask;
    logic wrBase;
  } ctlStrobe_t;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;
  localparam logic [1:0] ADDR_PEND = 2'd3;
endpackage

// File: rtl/prioIntSeq.sv
module prioIntSeq
  import prioIntPkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EOI_CODE = 8'h20,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] pending,
  input  logic [NUM_LEVELS-1:0] inService,
  input  logic [NUM_LEVELS-1:0] lvlMask,
  input  logic                  busWr,
  input  logic [1:0]            busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic                  intAck,
  output ctlStrobe_t            strobe,
  output logic [NUM_LEVELS-1:0] grantHot,
  output logic [NUM_LEVELS-1:0] eoiHot,
  output logic                  intReq,
  output logic [LVL_W-1:0]      ackLevel
);
  // lowest set index wins (level 0 is highest priority)
  function automatic logic [LVL_W-1:0] firstSet(input logic [NUM_LEVELS-1:0] v);
    logic [LVL_W-1:0] idx;
    idx = '1;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (v[i]) idx = i[LVL_W-1:0];
    end
    return idx;
  endfunction

  logic [NUM_LEVELS-1:0] eligible;
  logic [LVL_W-1:0]      reqTop;
  logic [LVL_W-1:0]      svcTop;
  logic                  reqValid;
  logic                  svcValid;
  logic                  outranks;

  always_comb begin
    eligible = pending & ~lvlMask;
    reqValid = |eligible;
    svcValid = |inService;
    reqTop   = firstSet(eligible);
    svcTop   = firstSet(inService);
    outranks = reqValid && (!svcValid || (reqTop < svcTop));
  end

  always_comb begin
    strobe.grant  = intAck && outranks;
    strobe.eoi    = busWr && (busAddr == ADDR_CMD) && (busWrData == EOI_CODE) && svcValid;
    strobe.wrMask = busWr && (busAddr == ADDR_MASK);
    strobe.wrBase = busWr && (busAddr == ADDR_BASE);
    grantHot = strobe.grant ? (NUM_LEVELS'(1) << reqTop) : '0;
    eoiHot   = strobe.eoi ? (NUM_LEVELS'(1) << svcTop) : '0;
    intReq   = outranks;
    ackLevel = outranks ? reqTop : '1;
  end
endmodule

// File: rtl/prioIntRegs.sv
module prioIntRegs
  import prioIntPkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  ctlStrobe_t            strobe,
  input  logic [NUM_LEVELS-1:0] grantHot,
  input  logic [NUM_LEVELS-1:0] eoiHot,
  input  logic [1:0]            busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic [LVL_W-1:0]      ackLevel,
  output logic [NUM_LEVELS-1:0] pending,
  output logic [NUM_LEVELS-1:0] inService,
  output logic [NUM_LEVELS-1:0] lvlMask,
  output logic [DATA_W-1:0]     busRdData,
  output logic [DATA_W-1:0]     intVec
);
  logic [NUM_LEVELS-1:0] irqPrev;
  logic [DATA_W-1:0]     baseReg;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gLevel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqPrev[g]   <= 1'b0;
        pending[g]   <= 1'b0;
        inService[g] <= 1'b0;
      end else begin
        irqPrev[g] <= irqIn[g];
        if (irqIn[g] && !irqPrev[g]) pending[g] <= 1'b1;
        else if (grantHot[g])        pending[g] <= 1'b0;
        if (grantHot[g])             inService[g] <= 1'b1;
        else if (eoiHot[g])          inService[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlMask <= '0;
      baseReg <= '0;
    end else begin
      if (strobe.wrMask) lvlMask <= busWrData[NUM_LEVELS-1:0];
      if (strobe.wrBase) baseReg <= busWrData;
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CMD:  busRdData[NUM_LEVELS-1:0] = inService;
      ADDR_MASK: busRdData[NUM_LEVELS-1:0] = lvlMask;
      ADDR_BASE: busRdData = baseReg;
      default:   busRdData[NUM_LEVELS-1:0] = pending;
    endcase
    intVec = {baseReg[DATA_W-1:LVL_W], ackLevel};
  end
endmodule

// File: rtl/prioIntCtrl.sv
module prioIntCtrl
  import prioIntPkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EOI_CODE = 8'h20,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  logic                  busWr,
  input  logic [1:0]            busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic                  intOut,
  input  logic                  intAck,
  output logic [DATA_W-1:0]     intVec
);
  ctlStrobe_t            strobe;
  logic [NUM_LEVELS-1:0] pending;
  logic [NUM_LEVELS-1:0] inService;
  logic [NUM_LEVELS-1:0] lvlMask;
  logic [NUM_LEVELS-1:0] grantHot;
  logic [NUM_LEVELS-1:0] eoiHot;
  logic [LVL_W-1:0]      ackLevel;

  prioIntSeq #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W), .EOI_CODE(EOI_CODE)) seq (
    .pending(pending), .inService(inService), .lvlMask(lvlMask),
    .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData), .intAck(intAck),
    .strobe(strobe), .grantHot(grantHot), .eoiHot(eoiHot),
    .intReq(intOut), .ackLevel(ackLevel)
  );

  prioIntRegs #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W)) regs (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobe(strobe),
    .grantHot(grantHot), .eoiHot(eoiHot), .busAddr(busAddr),
    .busWrData(busWrData), .ackLevel(ackLevel),
    .pending(pending), .inService(inService), .lvlMask(lvlMask),
    .busRdData(busRdData), .intVec(intVec)
  );
endmodule

// File: rtl/prioIntCheck.sv
module prioIntCheck #(
  parameter int NUM_LEVELS = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EOI_CODE = 8'h20,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  intAck,
  input logic                  intOut,
  input logic [DATA_W-1:0]     intVec,
  input logic                  busWr,
  input logic [1:0]            busAddr,
  input logic [DATA_W-1:0]     busWrData,
  input logic [NUM_LEVELS-1:0] pending,
  input logic [NUM_LEVELS-1:0] inService,
  input logic [NUM_LEVELS-1:0] lvlMask
);
  a_r5_grant_adds_service: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut) |=> ($countones(inService) == $countones($past(inService)) + 1));

  a_r5_vec_names_pending: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut) |-> pending[intVec[LVL_W-1:0]]);

  a_r4_masked_never_chosen: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut) |-> !lvlMask[intVec[LVL_W-1:0]]);

  a_r6_chosen_outranks_service: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut) |-> ((inService & ((NUM_LEVELS'(1) << intVec[LVL_W-1:0]) - 1'b1)) == '0)
      && !inService[intVec[LVL_W-1:0]]);

  a_r8_spurious_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intOut && !busWr) |=> ($stable(inService) && intVec[LVL_W-1:0] == '1));

  a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd0 && busWrData == EOI_CODE && inService != '0 && !intAck)
      |=> ($countones(inService) + 1 == $countones($past(inService))));
endmodule

bind prioIntCtrl prioIntCheck #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W), .EOI_CODE(EOI_CODE)) chk (
  .clk(clk), .rstN(rstN), .intAck(intAck), .intOut(intOut), .intVec(intVec),
  .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
  .pending(pending), .inService(inService), .lvlMask(lvlMask)
);

// File: tb/prioIntCtrl_test.sv
module prioIntCtrl_test;
  localparam time CYCLE = 4ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       intOut;
  logic       intAck = 1'b0;
  logic [7:0] intVec;

  int checks = 0;
  int errors = 0;

  always #(CYCLE / 2) clk = ~clk;

  prioIntCtrl uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .intOut(intOut),
    .intAck(intAck), .intVec(intVec)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; irqIn = '0; busWr = 1'b0; intAck = 1'b0; busAddr = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // reads combinationally, at a point after a falling edge
  task automatic readReg(input logic [1:0] addr, output logic [7:0] val);
    busAddr = addr;
    #1;
    val = busRdData;
  endtask

  task automatic writeReg(input logic [1:0] addr, input logic [7:0] val);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWrData = val;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // new edge on a line; pending is visible at the next falling edge
  task automatic raiseIrq(input int lvl);
    @(negedge clk);
    irqIn[lvl] = 1'b1;
    @(negedge clk);
  endtask

  task automatic dropIrq(input int lvl);
    @(negedge clk);
    irqIn[lvl] = 1'b0;
    @(negedge clk);
  endtask

  task automatic acknowledge(output logic [7:0] vec);
    @(negedge clk);
    intAck = 1'b1;
    #1;
    vec = intVec;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    doReset();
    check("R1 intOut", {7'd0, intOut}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], v);
      check("R1/R9 register after reset", v, 8'h00);
    end
  endtask

  task automatic tSingle();
    logic [7:0] v;
    doReset();
    raiseIrq(3);
    check("R3 intOut on request", {7'd0, intOut}, 8'h01);
    readReg(2'd3, v);
    check("R2 pending bit 3", v, 8'h08);
    acknowledge(v);
    check("R5 vector level 3", v, 8'h03);
    readReg(2'd0, v);
    check("R5 in-service after ack", v, 8'h08);
    readReg(2'd3, v);
    check("R5 pending cleared", v, 8'h00);
    check("R3 intOut drops", {7'd0, intOut}, 8'h00);
    repeat (3) @(negedge clk);
    readReg(2'd3, v);
    check("R2 held line no re-request", v, 8'h00);
    dropIrq(3);
  endtask

  task automatic tPriority();
    logic [7:0] v;
    doReset();
    @(negedge clk);
    irqIn[5] = 1'b1; irqIn[2] = 1'b1;
    @(negedge clk);
    readReg(2'd3, v);
    check("R2 two pending", v, 8'h24);
    acknowledge(v);
    check("R5 lowest number wins", v, 8'h02);
    readReg(2'd0, v);
    check("R5 in-service 2", v, 8'h04);
    check("R6 lower level held off", {7'd0, intOut}, 8'h00);
  endtask

  task automatic tNest();
    logic [7:0] v;
    doReset();
    raiseIrq(4);
    acknowledge(v);
    dropIrq(4);
    raiseIrq(4);
    readReg(2'd3, v);
    check("R2 repeat edge pends", v, 8'h10);
    check("R6 equal level held off", {7'd0, intOut}, 8'h00);
    raiseIrq(1);
    check("R6 higher level asks", {7'd0, intOut}, 8'h01);
    acknowledge(v);
    check("R6 nested vector", v, 8'h01);
    readReg(2'd0, v);
    check("R6 two in service", v, 8'h12);
    writeReg(2'd0, 8'h20);
    readReg(2'd0, v);
    check("R7 EOI clears top level", v, 8'h10);
    check("R3 still blocked by level 4", {7'd0, intOut}, 8'h00);
    writeReg(2'd0, 8'h20);
    readReg(2'd0, v);
    check("R7 second EOI", v, 8'h00);
    check("R3 pending level 4 now asks", {7'd0, intOut}, 8'h01);
  endtask

  task automatic tMask();
    logic [7:0] v;
    doReset();
    writeReg(2'd1, 8'h40);
    readReg(2'd1, v);
    check("R9 mask readback", v, 8'h40);
    raiseIrq(6);
    check("R4 masked no intOut", {7'd0, intOut}, 8'h00);
    readReg(2'd3, v);
    check("R4 masked stays pending", v, 8'h40);
    raiseIrq(7);
    acknowledge(v);
    check("R4 masked level skipped", v, 8'h07);
    writeReg(2'd1, 8'h00);
    check("R4 unmask reactivates", {7'd0, intOut}, 8'h01);
  endtask

  task automatic tCommand();
    logic [7:0] v;
    doReset();
    raiseIrq(0);
    acknowledge(v);
    writeReg(2'd0, 8'h21);
    readReg(2'd0, v);
    check("R7 other command ignored", v, 8'h01);
    writeReg(2'd0, 8'h00);
    readReg(2'd0, v);
    check("R7 zero command ignored", v, 8'h01);
    writeReg(2'd0, 8'h20);
    readReg(2'd0, v);
    check("R7 EOI clears level 0", v, 8'h00);
  endtask

  task automatic tBase();
    logic [7:0] v;
    doReset();
    writeReg(2'd2, 8'h4D);
    readReg(2'd2, v);
    check("R9 base readback", v, 8'h4D);
    raiseIrq(2);
    acknowledge(v);
    check("R5 base low bits replaced", v, 8'h4A);
  endtask

  task automatic tSpurious();
    logic [7:0] v;
    doReset();
    writeReg(2'd2, 8'h80);
    acknowledge(v);
    check("R8 spurious vector", v, 8'h87);
    readReg(2'd0, v);
    check("R8 no service started", v, 8'h00);
    writeReg(2'd1, 8'h01);
    raiseIrq(0);
    acknowledge(v);
    check("R8 masked only spurious", v, 8'h87);
    readReg(2'd3, v);
    check("R8 pending kept", v, 8'h01);
    readReg(2'd0, v);
    check("R8 in-service untouched", v, 8'h00);
  endtask

  initial begin
    #(CYCLE * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tSingle();
    tPriority();
    tNest();
    tMask();
    tCommand();
    tBase();
    tSpurious();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule